// File: doc/BRIEF.md
# Flash Multi-Block Erase Sequencer

This controller carries out the pulse-and-check erase algorithm for a flash array split into a small number of independently selectable blocks. Software first zero-fills the target blocks, raises the prewrite-done input, presents a block mask and pulses start. The sequencer then alternates erase pulses with a byte-by-byte verify pass. Blocks that read back fully erased drop out of the select mask, so each later pulse reaches only blocks that still need it.

Erase pulse lengths grow geometrically over the first few attempts and then stay fixed. The attempt count is capped. Every wait is counted in ticks of a free-running prescaler. The initial pulse length and the two verify settle delays are inputs, and the block address table is computed at elaboration time from a base block size, with block i spanning BLK_BASE·2^i bytes laid out back to back from address 0. The outcome is given by a one-cycle done or error pulse and a sticky status code.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, every flash control output, the watchdog enable, busy, done and error are 0 and the status code is 0 (none).
- R2: A start while prewrite-done is low produces an error pulse with status code 4, and no erase pulse.
- R3: A start with an initial pulse of 0, an initial pulse above INIT_MAX, an initial pulse times 8 above PULSE_MAX, a first verify delay below VS1_MIN or a second verify delay below VS2_MIN produces an error pulse with status code 3, and no erase pulse.
- R4: The watchdog enable rises at least one cycle before the erase bit rises and falls at least one cycle after it falls; erase and verify are never high together.
- R5: Erase pulse n lasts init·2^min(n-1,3) ticks, within one tick of prescaler phase.
- R6: The verify bit is high for at least the first verify delay before the first access; each access is a byte write of 0xFF followed in the next cycle by a read of the same address, and both happen only while verify is high.
- R7: Within a verify pass, still-selected blocks are visited in ascending block order, each from its lowest address upward one byte per access; the first read differing from 0xFF ends that block's scan; a block whose every byte reads 0xFF is deselected and receives no further pulse.
- R8: After a verify pass, verify stays low for at least the second verify delay before the next watchdog rise or the completion pulse.
- R9: When every select bit is clear after a pass, the block emits a done pulse with status code 1.
- R10: When blocks remain selected after MAX_TRY pulses, the block emits an error pulse with status code 2 and issues no further pulse.
- R11: Done and error are single-cycle pulses, never together, and a start while busy is ignored.
- R12: A start with an all-zero mask and a valid setup produces a done pulse with status code 1 and no erase pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled when idle |
| prewrite_done_i | input | 1 | Target blocks already hold 0x00 |
| blk_mask_i | input | NUM_BLK | Blocks to erase |
| init_pulse_i | input | PW | First pulse length in ticks |
| vs1_i | input | PW | Settle delay after verify rises, ticks |
| vs2_i | input | PW | Settle delay after verify falls, ticks |
| fl_erase_o | output | 1 | Erase enable bit |
| fl_verify_o | output | 1 | Erase-verify enable bit |
| fl_blk_sel_o | output | NUM_BLK | Per-block erase select |
| wdt_en_o | output | 1 | Watchdog enable around each pulse |
| fl_addr_o | output | ADDR_W | Byte address for verify accesses |
| fl_wdata_o | output | 8 | Dummy write data |
| fl_we_o | output | 1 | Dummy write strobe |
| fl_re_o | output | 1 | Read strobe; data returns next cycle |
| fl_rdata_i | input | 8 | Read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure or refusal pulse |
| status_o | output | 3 | Sticky result code |

## Verification
The bench builds the sequencer with a 4-cycle tick, a 4-byte base block (blocks of 4, 8, 16 and 32 bytes), INIT_MAX of 4 ticks, PULSE_MAX of 28 ticks and an attempt cap of 6. These values put the whole doubling ladder, the plateau at eight times the initial length and the attempt ceiling within a few thousand cycles. They also let both configuration limits be tripped separately: an initial length of 4 breaks only the pulse ceiling, and 5 breaks the initial limit. A flash model erases each block after a set number of pulses, so one-pulse, staggered, exactly-at-cap and beyond-cap cases are all reachable.

// File: rtl/erase_pkg.sv
package erase_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WDT_ON,
        S_ERASE,
        S_ERASE_OFF,
        S_VSETUP,
        S_VNEXT,
        S_VWR,
        S_VRD,
        S_VCHK,
        S_VEXIT
    } seq_state_e;

    typedef enum logic [2:0] {
        ST_NONE  = 3'd0,
        ST_OK    = 3'd1,
        ST_FAIL  = 3'd2,
        ST_CFG   = 3'd3,
        ST_NOPRE = 3'd4
    } seq_status_e;

    typedef struct packed {
        logic wdt;
        logic erase;
        logic verify;
        logic we;
        logic re;
    } fl_ctl_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    // Block i holds base << i bytes, blocks packed from address 0.
    function automatic int unsigned blk_lo(int unsigned i, int unsigned base);
        return base * ((32'd1 << i) - 32'd1);
    endfunction

    function automatic int unsigned blk_hi(int unsigned i, int unsigned base);
        return base * ((32'd1 << (i + 1)) - 32'd1) - 32'd1;
    endfunction

endpackage

// File: rtl/erase_tick.sv
module erase_tick #(
    parameter int DIV = 125
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i || cnt == CW'(DIV - 1)) cnt <= '0;
        else                              cnt <= cnt + 1'b1;
    end

    assign tick_o = (cnt == CW'(DIV - 1));
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i)                    cnt <= '0;
        else if (load_i)              cnt <= load_val_i;
        else if (tick_i && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired_o = (cnt == '0);
endmodule

// File: rtl/erase_cfg_chk.sv
module erase_cfg_chk #(
    parameter int PW        = 16,
    parameter int INIT_MAX  = 6250,
    parameter int PULSE_MAX = 50000,
    parameter int VS1_MIN   = 4,
    parameter int VS2_MIN   = 2,
    parameter int DOUBLINGS = 3
) (
    input  logic [PW-1:0] init_i,
    input  logic [PW-1:0] vs1_i,
    input  logic [PW-1:0] vs2_i,
    output logic          bad_o
);
    localparam int XW = PW + DOUBLINGS;

    logic [XW-1:0] longest;

    always_comb begin
        longest = XW'(init_i) << DOUBLINGS;
        bad_o   = (init_i == '0)
               || (32'(init_i)  > 32'(INIT_MAX))
               || (32'(longest) > 32'(PULSE_MAX))
               || (32'(vs1_i)   < 32'(VS1_MIN))
               || (32'(vs2_i)   < 32'(VS2_MIN));
    end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import erase_pkg::*;
#(
    parameter int NUM_BLK   = 4,
    parameter int ADDR_W    = 8,
    parameter int BLK_BASE  = 16,
    parameter int PW        = 16,
    parameter int TICK_DIV  = 125,
    parameter int INIT_MAX  = 6250,
    parameter int PULSE_MAX = 50000,
    parameter int VS1_MIN   = 4,
    parameter int VS2_MIN   = 2,
    parameter int MAX_TRY   = 602,
    parameter int DOUBLINGS = 3
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               start_i,
    input  logic               prewrite_done_i,
    input  logic [NUM_BLK-1:0] blk_mask_i,
    input  logic [PW-1:0]      init_pulse_i,
    input  logic [PW-1:0]      vs1_i,
    input  logic [PW-1:0]      vs2_i,
    output logic               fl_erase_o,
    output logic               fl_verify_o,
    output logic [NUM_BLK-1:0] fl_blk_sel_o,
    output logic               wdt_en_o,
    output logic [ADDR_W-1:0]  fl_addr_o,
    output logic [7:0]         fl_wdata_o,
    output logic               fl_we_o,
    output logic               fl_re_o,
    input  logic [7:0]         fl_rdata_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o,
    output logic [2:0]         status_o
);
    localparam int BW = (NUM_BLK > 2) ? $clog2(NUM_BLK) : 1;
    localparam int TW = $clog2(MAX_TRY + 1);

    seq_state_e        state;
    seq_status_e       status;
    fl_ctl_t           ctl;
    logic [NUM_BLK-1:0] sel;
    logic [BW-1:0]     blk_idx;
    logic              scan_end;
    logic [ADDR_W-1:0] addr;
    logic [TW-1:0]     tries;
    logic [PW-1:0]     cur_pulse;
    logic              tick, expired, cfg_bad, tmr_load;
    logic [PW-1:0]     tmr_val;
    logic [ADDR_W-1:0] lo_tab [NUM_BLK];
    logic [ADDR_W-1:0] hi_tab [NUM_BLK];

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_map
        assign lo_tab[g] = ADDR_W'(blk_lo(g, BLK_BASE));
        assign hi_tab[g] = ADDR_W'(blk_hi(g, BLK_BASE));
    end

    erase_tick #(.DIV(TICK_DIV)) u_tick (
        .clk_i(clk_i), .rst_i(rst_i), .tick_o(tick)
    );

    erase_timer #(.W(PW)) u_timer (
        .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick),
        .load_i(tmr_load), .load_val_i(tmr_val), .expired_o(expired)
    );

    erase_cfg_chk #(
        .PW(PW), .INIT_MAX(INIT_MAX), .PULSE_MAX(PULSE_MAX),
        .VS1_MIN(VS1_MIN), .VS2_MIN(VS2_MIN), .DOUBLINGS(DOUBLINGS)
    ) u_cfg (
        .init_i(init_pulse_i), .vs1_i(vs1_i), .vs2_i(vs2_i), .bad_o(cfg_bad)
    );

    // Timer loads: pulse length on the way into the pulse, settle delays
    // on the way into each verify phase.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = cur_pulse;
        case (state)
            S_WDT_ON:    tmr_load = 1'b1;
            S_ERASE_OFF: begin tmr_load = 1'b1; tmr_val = vs1_i; end
            S_VNEXT:     begin tmr_load = scan_end; tmr_val = vs2_i; end
            default: ;
        endcase
    end

    always_comb begin
        ctl        = '0;
        ctl.wdt    = state inside {S_WDT_ON, S_ERASE, S_ERASE_OFF};
        ctl.erase  = (state == S_ERASE);
        ctl.verify = state inside {S_VSETUP, S_VNEXT, S_VWR, S_VRD, S_VCHK};
        ctl.we     = (state == S_VWR);
        ctl.re     = (state == S_VRD);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state     <= S_IDLE;
            status    <= ST_NONE;
            sel       <= '0;
            blk_idx   <= '0;
            scan_end  <= 1'b0;
            addr      <= '0;
            tries     <= '0;
            cur_pulse <= '0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (state)
                S_IDLE: if (start_i) begin
                    if (!prewrite_done_i) begin
                        err_o  <= 1'b1;
                        status <= ST_NOPRE;
                    end else if (cfg_bad) begin
                        err_o  <= 1'b1;
                        status <= ST_CFG;
                    end else if (blk_mask_i == '0) begin
                        done_o <= 1'b1;
                        status <= ST_OK;
                    end else begin
                        sel       <= blk_mask_i;
                        cur_pulse <= init_pulse_i;
                        tries     <= TW'(1);
                        state     <= S_WDT_ON;
                    end
                end
                S_WDT_ON:    state <= S_ERASE;
                S_ERASE:     if (expired) state <= S_ERASE_OFF;
                S_ERASE_OFF: state <= S_VSETUP;
                S_VSETUP: if (expired) begin
                    blk_idx  <= '0;
                    scan_end <= 1'b0;
                    state    <= S_VNEXT;
                end
                S_VNEXT: begin
                    if (scan_end) begin
                        state <= S_VEXIT;
                    end else if (sel[blk_idx]) begin
                        addr  <= lo_tab[blk_idx];
                        state <= S_VWR;
                    end else if (blk_idx == BW'(NUM_BLK - 1)) begin
                        scan_end <= 1'b1;
                    end else begin
                        blk_idx <= blk_idx + 1'b1;
                    end
                end
                S_VWR: state <= S_VRD;
                S_VRD: state <= S_VCHK;
                S_VCHK: begin
                    if (fl_rdata_i != ERASED_BYTE || addr == hi_tab[blk_idx]) begin
                        if (fl_rdata_i == ERASED_BYTE) sel[blk_idx] <= 1'b0;
                        if (blk_idx == BW'(NUM_BLK - 1)) scan_end <= 1'b1;
                        else                            blk_idx  <= blk_idx + 1'b1;
                        state <= S_VNEXT;
                    end else begin
                        addr  <= addr + 1'b1;
                        state <= S_VWR;
                    end
                end
                S_VEXIT: if (expired) begin
                    if (sel == '0) begin
                        done_o <= 1'b1;
                        status <= ST_OK;
                        state  <= S_IDLE;
                    end else if (32'(tries) >= 32'(MAX_TRY)) begin
                        err_o  <= 1'b1;
                        status <= ST_FAIL;
                        state  <= S_IDLE;
                    end else begin
                        if (32'(tries) <= 32'(DOUBLINGS)) cur_pulse <= cur_pulse << 1;
                        tries <= tries + 1'b1;
                        state <= S_WDT_ON;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy_o       = (state != S_IDLE);
    assign fl_erase_o   = ctl.erase;
    assign fl_verify_o  = ctl.verify;
    assign wdt_en_o     = ctl.wdt;
    assign fl_we_o      = ctl.we;
    assign fl_re_o      = ctl.re;
    assign fl_addr_o    = addr;
    assign fl_wdata_o   = ctl.we ? ERASED_BYTE : 8'h00;
    assign fl_blk_sel_o = busy_o ? sel : '0;
    assign status_o     = status;
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
    parameter int NUM_BLK   = 4,
    parameter int PULSE_MAX = 50000,
    parameter int TICK_DIV  = 125
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               fl_erase_o,
    input logic               fl_verify_o,
    input logic               wdt_en_o,
    input logic               fl_we_o,
    input logic               fl_re_o,
    input logic               busy_o,
    input logic               done_o,
    input logic               err_o,
    input logic [NUM_BLK-1:0] fl_blk_sel_o
);
    int unsigned erase_run;

    always_ff @(posedge clk_i) begin
        if (rst_i || !fl_erase_o) erase_run <= 0;
        else                      erase_run <= erase_run + 1;
    end

    a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (rst_i)
        !(fl_erase_o && fl_verify_o));
    a_r4_wdt_covers: assert property (@(posedge clk_i) disable iff (rst_i)
        fl_erase_o |-> wdt_en_o);
    a_r4_wdt_first: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(fl_erase_o) |-> $past(wdt_en_o));
    a_r4_wdt_last: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(fl_erase_o) |-> wdt_en_o);
    a_r5_pulse_cap: assert property (@(posedge clk_i) disable iff (rst_i)
        erase_run <= PULSE_MAX * TICK_DIV + 2);
    a_r6_access_in_verify: assert property (@(posedge clk_i) disable iff (rst_i)
        (fl_we_o || fl_re_o) |-> fl_verify_o);
    a_r6_read_after_write: assert property (@(posedge clk_i) disable iff (rst_i)
        fl_re_o |-> $past(fl_we_o));
    a_r7_sel_only_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && $past(busy_o)) |-> ((fl_blk_sel_o & ~$past(fl_blk_sel_o)) == '0));
    a_r11_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);
    a_r11_err_single: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |=> !err_o);
    a_r11_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(done_o && err_o));
endmodule

bind flash_erase_seq erase_seq_chk #(
    .NUM_BLK(NUM_BLK), .PULSE_MAX(PULSE_MAX), .TICK_DIV(TICK_DIV)
) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .fl_erase_o(fl_erase_o),
    .fl_verify_o(fl_verify_o), .wdt_en_o(wdt_en_o), .fl_we_o(fl_we_o),
    .fl_re_o(fl_re_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .fl_blk_sel_o(fl_blk_sel_o)
);

// File: tb/sim_flash_erase_seq.sv
`timescale 1ns/1ps
module sim_flash_erase_seq;
    localparam int NB = 4, AW = 8, BASE = 4, PW = 8, DIV = 4;
    localparam int IMAX = 4, PMAX = 28, V1MIN = 4, V2MIN = 2, NTRY = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0, pre = 1'b1;
    logic [NB-1:0] mask = '0;
    logic [PW-1:0] init = 8'd2, vs1 = 8'd4, vs2 = 8'd2;
    logic er, vf, wdt, we, re, busy, done, err;
    logic [NB-1:0] bsel;
    logic [AW-1:0] addr;
    logic [7:0] wdata, rdata = 8'h00;
    logic [2:0] status;

    always #4 clk = ~clk;

    flash_erase_seq #(
        .NUM_BLK(NB), .ADDR_W(AW), .BLK_BASE(BASE), .PW(PW), .TICK_DIV(DIV),
        .INIT_MAX(IMAX), .PULSE_MAX(PMAX), .VS1_MIN(V1MIN), .VS2_MIN(V2MIN),
        .MAX_TRY(NTRY), .DOUBLINGS(3)
    ) u0 (
        .clk_i(clk), .rst_i(rst), .start_i(start), .prewrite_done_i(pre),
        .blk_mask_i(mask), .init_pulse_i(init), .vs1_i(vs1), .vs2_i(vs2),
        .fl_erase_o(er), .fl_verify_o(vf), .fl_blk_sel_o(bsel), .wdt_en_o(wdt),
        .fl_addr_o(addr), .fl_wdata_o(wdata), .fl_we_o(we), .fl_re_o(re),
        .fl_rdata_i(rdata), .busy_o(busy), .done_o(done), .err_o(err),
        .status_o(status)
    );

    int n_tests = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int first_of(input int b);
        int f = 0;
        for (int k = 0; k < b; k++) f += BASE << k;
        return f;
    endfunction

    function automatic int block_of(input int a);
        for (int k = 0; k < NB; k++)
            if (a >= first_of(k) && a < first_of(k + 1)) return k;
        return -1;
    endfunction

    // flash model
    int need [NB];
    int got  [NB];
    int fail_off [NB];
    initial for (int k = 0; k < NB; k++) fail_off[k] = 2 * k + 1;

    always @(posedge clk) if (re) begin
        int b, off;
        b = block_of(int'(addr));
        off = int'(addr) - first_of(b);
        rdata <= (got[b] >= need[b] || off < fail_off[b]) ? 8'hFF : 8'h00;
    end

    // monitor
    int pulses = 0, elen = 0, vhi = 0, vlo = 0, dones = 0, errs = 0;
    int last_addr = -1, last_blk = -1;
    bit prev_er = 0, prev_wdt = 0, prev_vf = 0, prev_done = 0, prev_err = 0;
    bit first_acc = 0, vlo_on = 0, wpend = 0, last_pass = 0;
    int wr_addr = 0;

    always @(negedge clk) begin
        if (start && !busy) begin
            pulses = 0; dones = 0; errs = 0; vlo_on = 0;
            for (int k = 0; k < NB; k++) got[k] = 0;
        end
        if (er) elen++;
        if (er && !prev_er) check(prev_wdt, "R4 wdt before erase", 0, 1);
        if (!er && prev_er) begin
            int t, lo, hi;
            pulses++;
            t = int'(init) << ((pulses - 1 < 3) ? pulses - 1 : 3);
            lo = (t - 1) * DIV + 1; hi = t * DIV + 2;
            check(elen >= lo && elen <= hi, "R5 pulse length", elen, t * DIV);
            check(wdt, "R4 wdt after erase", 0, 1);
            for (int k = 0; k < NB; k++) if (bsel[k]) got[k]++;
            elen = 0;
        end
        if (wdt && !prev_wdt && vlo_on)
            check(vlo >= (int'(vs2) - 1) * DIV + 1, "R8 second delay", vlo, int'(vs2) * DIV);
        if ((done || err) && vlo_on)
            check(vlo >= (int'(vs2) - 1) * DIV + 1, "R8 second delay", vlo, int'(vs2) * DIV);
        if (wdt && !prev_wdt) vlo_on = 0;
        if (vf && !prev_vf) begin vhi = 0; first_acc = 1; last_blk = -1; last_addr = -1; end
        if (!vf && prev_vf) begin vlo = 0; vlo_on = 1; end
        if (vf) vhi++;
        if (!vf) vlo++;
        if (we) begin
            int b;
            b = block_of(int'(addr));
            if (first_acc)
                check(vhi >= (int'(vs1) - 1) * DIV + 1, "R6 first delay", vhi, int'(vs1) * DIV);
            first_acc = 0;
            check(wdata == 8'hFF, "R6 dummy data", wdata, 255);
            if (b == last_blk && last_pass)
                check(int'(addr) == last_addr + 1, "R7 ascending scan", addr, last_addr + 1);
            else
                check(b > last_blk && int'(addr) == first_of(b), "R7 block start", addr, first_of(b));
            check(bsel[b], "R7 scan selected only", 0, 1);
            wr_addr = int'(addr); wpend = 1;
            last_blk = b; last_addr = int'(addr);
        end
        if (re) begin
            int b, off;
            check(wpend && int'(addr) == wr_addr, "R6 read follows write", addr, wr_addr);
            wpend = 0;
            b = block_of(int'(addr));
            off = int'(addr) - first_of(b);
            last_pass = (got[b] >= need[b] || off < fail_off[b]);
        end
        if (done && prev_done) check(0, "R11 done width", 2, 1);
        if (err && prev_err) check(0, "R11 err width", 2, 1);
        if (done) dones++;
        if (err) errs++;
        prev_er = er; prev_wdt = wdt; prev_vf = vf; prev_done = done; prev_err = err;
    end

    typedef struct packed {
        logic [3:0]  mask;
        logic [15:0] need;
        logic [7:0]  init;
        logic [2:0]  st;
        logic [3:0]  np;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{4'h1, 16'h0001, 8'd2, 3'd1, 4'd1},
        '{4'hF, 16'h1321, 8'd2, 3'd1, 4'd3},
        '{4'h6, 16'h0245, 8'd1, 3'd1, 4'd4},
        '{4'h8, 16'h6000, 8'd3, 3'd1, 4'd6},
        '{4'h3, 16'h0017, 8'd2, 3'd2, 4'd6},
        '{4'h5, 16'h0505, 8'd3, 3'd1, 4'd5}
    };

    task automatic kick();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_end(output bit ok);
        int n = 0;
        ok = 0;
        while (n < 20000) begin
            @(negedge clk);
            if (done || err) begin ok = 1; break; end
            n++;
        end
        @(negedge clk);
        check(ok, "R9 run completes", 0, 1);
    endtask

    task automatic quick(input string req, input bit exp_err, input int exp_st);
        bit ok;
        kick();
        wait_end(ok);
        check(errs == int'(exp_err) && dones == int'(!exp_err), req, errs, int'(exp_err));
        check(int'(status) == exp_st, req, status, exp_st);
        check(pulses == 0, req, pulses, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        check(0, "R9 watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < NB; k++) begin need[k] = 1; got[k] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({er, vf, wdt, we, re, busy, done, err} == 8'h00, "R1 outputs idle", 1, 0);
        check(status == 3'd0 && bsel == '0, "R1 status", status, 0);

        for (int i = 0; i < 6; i++) begin
            bit ok;
            int total;
            for (int k = 0; k < NB; k++) need[k] = int'(VEC[i].need[4*k +: 4]);
            mask = VEC[i].mask; init = VEC[i].init; vs1 = 8'd4; vs2 = 8'd2; pre = 1'b1;
            kick();
            wait_end(ok);
            total = int'(VEC[i].np);
            check(int'(status) == int'(VEC[i].st),
                  VEC[i].st == 3'd2 ? "R10 fail status" : "R9 ok status", status, VEC[i].st);
            check(pulses == total, VEC[i].st == 3'd2 ? "R10 pulse count" : "R5 pulse count",
                  pulses, total);
            for (int k = 0; k < NB; k++) begin
                int e;
                e = mask[k] ? ((need[k] < total) ? need[k] : total) : 0;
                check(got[k] == e, "R7 per-block pulses", got[k], e);
            end
            check(!busy, "R9 idle after end", busy, 0);
        end

        // directed: refusals and config limits
        for (int k = 0; k < NB; k++) need[k] = 1;
        mask = 4'h1; init = 8'd2; pre = 1'b0;
        quick("R2 no prewrite", 1, 4);
        pre = 1'b1; init = 8'd0;  quick("R3 zero pulse", 1, 3);
        init = 8'd4;              quick("R3 pulse ceiling", 1, 3);
        init = 8'd5;              quick("R3 initial limit", 1, 3);
        init = 8'd3; vs1 = 8'd3;  quick("R3 first delay", 1, 3);
        vs1 = 8'd4; vs2 = 8'd1;   quick("R3 second delay", 1, 3);
        vs2 = 8'd2; mask = 4'h0;  quick("R12 empty mask", 0, 1);

        // R3 boundary: init 3 gives 24 <= 28, accepted
        begin
            bit ok;
            mask = 4'h1; init = 8'd3;
            kick(); wait_end(ok);
            check(int'(status) == 1 && pulses == 1, "R3 boundary accepted", status, 1);
        end

        // R11: start while busy ignored
        begin
            bit ok;
            mask = 4'h1; init = 8'd2; need[0] = 2;
            kick();
            repeat (10) @(negedge clk);
            mask = 4'hE;
            kick();
            wait_end(ok);
            repeat (5) @(negedge clk);
            check(dones == 1 && errs == 0, "R11 one completion", dones, 1);
            check(got[1] == 0 && got[2] == 0 && got[3] == 0, "R11 restart ignored",
                  got[1] + got[2] + got[3], 0);
            check(pulses == 2 && int'(status) == 1, "R11 run intact", pulses, 2);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule